// File: doc/BRIEF.md
# Transmit Gain Preset Selector

This block owns the 5-bit transmit gain code of an RF front-end controller and decides which value it holds at every moment. The code can come from a control-register write (a gain field plus a mode bit), or from one of two presets. A preset is reloaded whenever the external mode pin changes level or a register write flips the mode bit. A level of 1 selects preset B and a level of 0 selects preset A. When a write flips the mode bit, the preset reload takes priority over the gain carried in that same write.

Each preset is either a fixed production constant or a user value, and a per-preset select bit makes the choice. The user values and select bits live in two preset registers. At reset these registers are loaded from a one-time-programmable fuse array. A burn trigger copies the preset registers into the fuses after a programming delay. The new fuse contents become visible only after the next reset. While the front end is transmitting, gain changes are refused and flagged.

The state sequencing, the serial framing and the amplifier itself sit outside this block. The block sees the current state as three mutually exclusive strobes and sees register writes as single-cycle pulses.

Top module: `txgain_preset_ctrl`

## Requirements
- R1: Preset A equals the user A value when the A select bit is 1, and the production constant PROD_A otherwise. Preset B follows the same rule with its own select bit, its own user value and PROD_B. Gain codes are 5 bits, where 0 is the minimum and 31 the maximum.
- R2: While reset is high, the mode bit and tx_err are set to 0. The gain is set to the fuse-derived preset chosen by the synchronized mode pin level: 0 selects A and 1 selects B. Reset must be held for at least 3 cycles with the pin stable.
- R3: In program state (st_prog=1), a change of mode_pin reloads the gain. A rise loads preset B and a fall loads preset A. The pin passes through a 2-flop synchronizer, so the new gain appears after the third rising clock edge following the pin change.
- R4: In program state, a control write (ctl_wr=1) whose ctl_mode differs from the stored mode bit stores the new bit. On the next edge it reloads the gain from preset B if the new bit is 1, or from preset A if it is 0. The ctl_gain of that write is discarded.
- R5: Outside transmit state, a control write that does not trigger a reload stores ctl_gain into the gain on the next edge. This applies in program state and in the other non-transmit states.
- R6: In transmit state (st_tx=1), control writes and mode pin changes leave both the gain and the mode bit unchanged, and they set tx_err. tx_err stays 1 until reset.
- R7: Outside program and transmit states, a mode pin change does not reload the gain and does not set tx_err.
- R8: The preset registers accept writes (pa_wr, pb_wr) only in fuse programming state (st_otp=1). Writes in any other state are ignored.
- R9: A write to preset register A with pa_burn=1 in fuse programming state starts a burn, provided no burn is in progress. After BURN_CYCLES cycles, the fuses take the bitwise OR of their old contents and a snapshot of both preset registers as they stood after that write. A trigger that arrives during a burn is ignored.
- R10: Fuse contents reach the presets only through reset, which loads both preset registers from the fuses. Unprogrammed fuses are 0, which selects the production constants. Fuse bits are never cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| mode_pin | input | 1 | Asynchronous preset selection pin |
| st_prog | input | 1 | Front end is in program state |
| st_tx | input | 1 | Front end is in transmit state |
| st_otp | input | 1 | Front end is in fuse programming state |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_mode | input | 1 | Mode bit carried by the control write |
| ctl_gain | input | 5 | Gain field carried by the control write |
| pa_wr | input | 1 | Preset register A write strobe |
| pa_val | input | 5 | User value for preset A |
| pa_sel | input | 1 | Select bit for preset A (1 = user value) |
| pa_burn | input | 1 | Burn trigger carried by the A write |
| pb_wr | input | 1 | Preset register B write strobe |
| pb_val | input | 5 | User value for preset B |
| pb_sel | input | 1 | Select bit for preset B (1 = user value) |
| gain | output | 5 | Current transmit gain code |
| preset_a | output | 5 | Effective preset A |
| preset_b | output | 5 | Effective preset B |
| tx_err | output | 1 | Sticky flag for gain changes refused in transmit state |

## Verification
Control-write results and preset-register writes are due one edge after the strobe. The bench drives each strobe after a falling edge and samples on the next falling edge. Pin-driven reloads are due on the third rising edge after the pin changes. The bench therefore samples once after the second edge, to confirm the old gain still holds, and again after the third, to see the new value. Burn results are checked only after a reset that follows a wait longer than BURN_CYCLES, because before that reset the fuses cannot be observed at the ports.

// File: rtl/txg_pkg.sv
`timescale 1ns/1ps
package txg_pkg;
  localparam int GAIN_W = 5;
  typedef logic [GAIN_W-1:0] gain_t;
  typedef struct packed {
    logic  sel;
    gain_t val;
  } preset_cfg_t;
  typedef struct packed {
    preset_cfg_t a;
    preset_cfg_t b;
  } fuse_word_t;
endpackage

// File: rtl/txg_mode_sync.sv
`timescale 1ns/1ps
module txg_mode_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic pin,
  output logic level,
  output logic chg
);
  logic [STAGES-1:0] shift_q = '0;
  logic              prev_q  = 1'b0;

  always_ff @(posedge clk) begin
    shift_q <= {shift_q[STAGES-2:0], pin};
    prev_q  <= shift_q[STAGES-1];
  end

  assign level = shift_q[STAGES-1];
  assign chg   = shift_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/txg_preset_bank.sv
`timescale 1ns/1ps
module txg_preset_bank
  import txg_pkg::*;
#(
  parameter int PROD_A      = 29,
  parameter int PROD_B      = 16,
  parameter int BURN_CYCLES = 100000
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  st_otp,
  input  logic  pa_wr,
  input  gain_t pa_val,
  input  logic  pa_sel,
  input  logic  pa_burn,
  input  logic  pb_wr,
  input  gain_t pb_val,
  input  logic  pb_sel,
  output gain_t preset_a,
  output gain_t preset_b,
  output gain_t fuse_preset_a,
  output gain_t fuse_preset_b
);
  localparam int CNT_W = $clog2(BURN_CYCLES + 1);

  fuse_word_t       fuse_q = '0;
  fuse_word_t       cfg_q, cfg_nxt, snap_q;
  logic [CNT_W-1:0] cnt_q;
  logic             start;

  always_comb begin
    cfg_nxt = cfg_q;
    if (st_otp && pa_wr) begin
      cfg_nxt.a.sel = pa_sel;
      cfg_nxt.a.val = pa_val;
    end
    if (st_otp && pb_wr) begin
      cfg_nxt.b.sel = pb_sel;
      cfg_nxt.b.val = pb_val;
    end
  end

  assign start = st_otp && pa_wr && pa_burn && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= fuse_q;
      cnt_q  <= '0;
      snap_q <= '0;
    end else begin
      cfg_q <= cfg_nxt;
      if (start) begin
        cnt_q  <= CNT_W'(BURN_CYCLES);
        snap_q <= cfg_nxt;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  // fuse array: bits only ever set, never cleared, untouched by reset
  always_ff @(posedge clk) begin
    if (!rst && cnt_q == CNT_W'(1))
      fuse_q <= fuse_q | snap_q;
  end

  preset_cfg_t cur_cfg [2];
  preset_cfg_t fz_cfg  [2];
  gain_t       prod    [2];
  gain_t       cur_p   [2];
  gain_t       fz_p    [2];

  assign cur_cfg[0] = cfg_q.a;
  assign cur_cfg[1] = cfg_q.b;
  assign fz_cfg[0]  = fuse_q.a;
  assign fz_cfg[1]  = fuse_q.b;
  assign prod[0]    = GAIN_W'(PROD_A);
  assign prod[1]    = GAIN_W'(PROD_B);

  for (genvar i = 0; i < 2; i++) begin : g_mux
    assign cur_p[i] = cur_cfg[i].sel ? cur_cfg[i].val : prod[i];
    assign fz_p[i]  = fz_cfg[i].sel  ? fz_cfg[i].val  : prod[i];
  end

  assign preset_a      = cur_p[0];
  assign preset_b      = cur_p[1];
  assign fuse_preset_a = fz_p[0];
  assign fuse_preset_b = fz_p[1];
endmodule

// File: rtl/txgain_preset_ctrl.sv
`timescale 1ns/1ps
module txgain_preset_ctrl
  import txg_pkg::*;
#(
  parameter int PROD_A      = 29,
  parameter int PROD_B      = 16,
  parameter int BURN_CYCLES = 100000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_pin,
  input  logic              st_prog,
  input  logic              st_tx,
  input  logic              st_otp,
  input  logic              ctl_wr,
  input  logic              ctl_mode,
  input  logic [GAIN_W-1:0] ctl_gain,
  input  logic              pa_wr,
  input  logic [GAIN_W-1:0] pa_val,
  input  logic              pa_sel,
  input  logic              pa_burn,
  input  logic              pb_wr,
  input  logic [GAIN_W-1:0] pb_val,
  input  logic              pb_sel,
  output logic [GAIN_W-1:0] gain,
  output logic [GAIN_W-1:0] preset_a,
  output logic [GAIN_W-1:0] preset_b,
  output logic              tx_err
);
  logic  mode_lvl, mode_chg, mode_bit_q, err_q, bit_chg;
  gain_t gain_q, fz_a, fz_b, pre_a, pre_b;

  txg_mode_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .pin   (mode_pin),
    .level (mode_lvl),
    .chg   (mode_chg)
  );

  txg_preset_bank #(
    .PROD_A      (PROD_A),
    .PROD_B      (PROD_B),
    .BURN_CYCLES (BURN_CYCLES)
  ) u_bank (
    .clk           (clk),
    .rst           (rst),
    .st_otp        (st_otp),
    .pa_wr         (pa_wr),
    .pa_val        (pa_val),
    .pa_sel        (pa_sel),
    .pa_burn       (pa_burn),
    .pb_wr         (pb_wr),
    .pb_val        (pb_val),
    .pb_sel        (pb_sel),
    .preset_a      (pre_a),
    .preset_b      (pre_b),
    .fuse_preset_a (fz_a),
    .fuse_preset_b (fz_b)
  );

  assign bit_chg = ctl_wr && (ctl_mode != mode_bit_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      gain_q     <= mode_lvl ? fz_b : fz_a;
      mode_bit_q <= 1'b0;
      err_q      <= 1'b0;
    end else if (st_tx) begin
      if (ctl_wr || mode_chg)
        err_q <= 1'b1;
    end else begin
      if (ctl_wr)
        mode_bit_q <= ctl_mode;
      if (st_prog && bit_chg)
        gain_q <= ctl_mode ? pre_b : pre_a;
      else if (st_prog && mode_chg)
        gain_q <= mode_lvl ? pre_b : pre_a;
      else if (ctl_wr)
        gain_q <= ctl_gain;
    end
  end

  assign gain     = gain_q;
  assign preset_a = pre_a;
  assign preset_b = pre_b;
  assign tx_err   = err_q;
endmodule

// File: rtl/txg_checker.sv
`timescale 1ns/1ps
module txg_checker
  import txg_pkg::*;
(
  input logic  clk,
  input logic  rst,
  input logic  st_prog,
  input logic  st_tx,
  input logic  st_otp,
  input logic  ctl_wr,
  input logic  ctl_mode,
  input gain_t ctl_gain,
  input logic  mode_bit,
  input logic  mode_lvl,
  input logic  mode_chg,
  input gain_t gain,
  input gain_t preset_a,
  input gain_t preset_b,
  input logic  tx_err
);
  AST_TX_GAIN_HOLD: assert property (@(posedge clk) disable iff (rst)
    st_tx |=> $stable(gain)); // R6
  AST_TX_ERR_SET: assert property (@(posedge clk) disable iff (rst)
    st_tx && (ctl_wr || mode_chg) |=> tx_err); // R6
  AST_TX_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    tx_err |=> tx_err); // R6
  AST_BIT_RELOAD: assert property (@(posedge clk) disable iff (rst)
    st_prog && !st_tx && ctl_wr && (ctl_mode != mode_bit)
    |=> gain == ($past(ctl_mode) ? $past(preset_b) : $past(preset_a))); // R4
  AST_GAIN_WRITE: assert property (@(posedge clk) disable iff (rst)
    !st_tx && ctl_wr && (ctl_mode == mode_bit) && !(st_prog && mode_chg)
    |=> gain == $past(ctl_gain)); // R5
  AST_PIN_RELOAD: assert property (@(posedge clk) disable iff (rst)
    st_prog && !st_tx && mode_chg && !ctl_wr
    |=> gain == ($past(mode_lvl) ? $past(preset_b) : $past(preset_a))); // R3
  AST_NO_RELOAD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !st_prog && !st_tx && !ctl_wr |=> $stable(gain)); // R7
  AST_PRESET_LOCK: assert property (@(posedge clk) disable iff (rst)
    !st_otp |=> $stable(preset_a) && $stable(preset_b)); // R8
endmodule

bind txgain_preset_ctrl txg_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .st_prog  (st_prog),
  .st_tx    (st_tx),
  .st_otp   (st_otp),
  .ctl_wr   (ctl_wr),
  .ctl_mode (ctl_mode),
  .ctl_gain (ctl_gain),
  .mode_bit (mode_bit_q),
  .mode_lvl (mode_lvl),
  .mode_chg (mode_chg),
  .gain     (gain),
  .preset_a (preset_a),
  .preset_b (preset_b),
  .tx_err   (tx_err)
);

// File: tb/sim_txgain_preset_ctrl.sv
`timescale 1ns/1ps
module sim_txgain_preset_ctrl;
  localparam int PA = 29;
  localparam int PB = 16;
  localparam int BURN = 40;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_pin = 1'b0;
  logic       st_prog = 1'b0, st_tx = 1'b0, st_otp = 1'b0;
  logic       ctl_wr = 1'b0, ctl_mode = 1'b0;
  logic [4:0] ctl_gain = '0;
  logic       pa_wr = 1'b0, pa_sel = 1'b0, pa_burn = 1'b0;
  logic [4:0] pa_val = '0;
  logic       pb_wr = 1'b0, pb_sel = 1'b0;
  logic [4:0] pb_val = '0;
  logic [4:0] gain, preset_a, preset_b;
  logic       tx_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  txgain_preset_ctrl #(.PROD_A(PA), .PROD_B(PB), .BURN_CYCLES(BURN)) u0 (
    .clk(clk), .rst(rst), .mode_pin(mode_pin),
    .st_prog(st_prog), .st_tx(st_tx), .st_otp(st_otp),
    .ctl_wr(ctl_wr), .ctl_mode(ctl_mode), .ctl_gain(ctl_gain),
    .pa_wr(pa_wr), .pa_val(pa_val), .pa_sel(pa_sel), .pa_burn(pa_burn),
    .pb_wr(pb_wr), .pb_val(pb_val), .pb_sel(pb_sel),
    .gain(gain), .preset_a(preset_a), .preset_b(preset_b), .tx_err(tx_err)
  );

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic do_reset(input logic pin);
    mode_pin = pin;
    st_prog = 0; st_tx = 0; st_otp = 0;
    rst = 1'b1;
    step(4);
    rst = 1'b0;
    step(1);
  endtask

  task automatic ctl_write(input logic m, input logic [4:0] g);
    ctl_wr = 1; ctl_mode = m; ctl_gain = g;
    step(1);
    ctl_wr = 0;
  endtask

  task automatic pa_write(input logic s, input logic [4:0] v, input logic b);
    pa_wr = 1; pa_sel = s; pa_val = v; pa_burn = b;
    step(1);
    pa_wr = 0; pa_burn = 0;
  endtask

  task automatic pb_write(input logic s, input logic [4:0] v);
    pb_wr = 1; pb_sel = s; pb_val = v;
    step(1);
    pb_wr = 0;
  endtask

  task automatic t_reset_state;
    do_reset(1'b0);
    chk("R2 gain after reset pin=0", gain, PA);
    chk("R2 tx_err after reset", tx_err, 0);
    chk("R1 preset_a production", preset_a, PA);
    chk("R1 preset_b production", preset_b, PB);
    do_reset(1'b1);
    chk("R2 gain after reset pin=1", gain, PB);
  endtask

  task automatic t_pin_reload;
    do_reset(1'b0);
    st_prog = 1;
    ctl_write(1'b0, 5'd7);
    chk("R5 gain write program state", gain, 7);
    mode_pin = 1;
    step(2);
    chk("R3 gain held during sync", gain, 7);
    step(1);
    chk("R3 pin rise loads B", gain, PB);
    mode_pin = 0;
    step(3);
    chk("R3 pin fall loads A", gain, PA);
  endtask

  task automatic t_bit_reload;
    do_reset(1'b0);
    st_prog = 1;
    ctl_write(1'b1, 5'd3);
    chk("R4 bit set loads B, gain discarded", gain, PB);
    ctl_write(1'b1, 5'd9);
    chk("R5 same bit stores gain", gain, 9);
    ctl_write(1'b0, 5'd11);
    chk("R4 bit clear loads A", gain, PA);
  endtask

  task automatic t_tx_block;
    do_reset(1'b0);
    st_prog = 1;
    ctl_write(1'b0, 5'd12);
    st_prog = 0; st_tx = 1;
    step(1);
    chk("R6 no error before tx write", tx_err, 0);
    ctl_write(1'b1, 5'd1);
    chk("R6 tx write ignored", gain, 12);
    chk("R6 tx write sets error", tx_err, 1);
    mode_pin = 1;
    step(4);
    chk("R6 tx pin change ignored", gain, 12);
    st_tx = 0; st_prog = 1;
    mode_pin = 0;
    step(4);
    chk("R6 error sticky", tx_err, 1);
    ctl_write(1'b0, 5'd4);
    chk("R6 mode bit unchanged by tx write", gain, 4);
  endtask

  task automatic t_other_state;
    do_reset(1'b0);
    mode_pin = 1;
    step(4);
    chk("R7 pin change outside program no reload", gain, PA);
    chk("R7 no error outside program", tx_err, 0);
    ctl_write(1'b1, 5'd6);
    chk("R5 gain write in non-program state", gain, 6);
    mode_pin = 0;
    step(3);
  endtask

  task automatic t_preset_regs;
    do_reset(1'b0);
    st_prog = 1;
    pa_write(1'b1, 5'd3, 1'b0);
    chk("R8 preset A write ignored in program", preset_a, PA);
    st_prog = 0; st_otp = 1;
    pa_write(1'b1, 5'd3, 1'b0);
    chk("R1 user preset A selected", preset_a, 3);
    pb_write(1'b1, 5'd20);
    chk("R1 user preset B selected", preset_b, 20);
    pb_write(1'b0, 5'd20);
    chk("R1 select 0 gives production B", preset_b, PB);
  endtask

  task automatic t_burn;
    do_reset(1'b0);
    chk("R10 unprogrammed fuses give production A", preset_a, PA);
    st_otp = 1;
    pb_write(1'b1, 5'd20);
    pa_write(1'b1, 5'd3, 1'b1);
    step(5);
    pa_write(1'b1, 5'd28, 1'b1);
    chk("R8 register write during burn", preset_a, 28);
    step(BURN + 10);
    pa_write(1'b0, 5'd0, 1'b0);
    chk("R10 fuse not visible before reset", preset_a, PA);
    do_reset(1'b0);
    chk("R9 fused preset A after reset", preset_a, 3);
    chk("R9 fused preset B after reset", preset_b, 20);
    chk("R10 gain from fused A", gain, 3);
    st_otp = 1;
    pa_write(1'b0, 5'd8, 1'b1);
    step(BURN + 10);
    do_reset(1'b0);
    chk("R10 fuse bits only set (OR)", preset_a, 11);
    chk("R10 preset B kept", preset_b, 20);
  endtask

  initial begin
    step(2);
    t_reset_state();
    t_pin_reload();
    t_bit_reload();
    t_tx_block();
    t_other_state();
    t_preset_regs();
    t_burn();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule